// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

The block turns the two phase signals of an incremental rotary or linear encoder into a signed position count. Both phase inputs pass through a two-flop synchroniser. On each sample tick the block compares the two-bit phase state it saw last with the state it sees now. From that comparison it adds one to the count, subtracts one, or leaves the count alone. The count is a two's complement register that wraps, so a host that subtracts two readings gets the true movement even across overflow.

After every sample the block offers the updated count to a small receive queue. It never waits for space. When the queue is full, the new value is discarded and sampling goes on. The host pops entries through a request/valid read port and can see the queue occupancy. Entries already in the queue may be old. To get a fresh position, the host pops as many entries as the queue holds and then one more, and uses that last value.

A divisor input sets how often the block samples. A low sampling rate saves power when the encoder is slow. The host derives the divisor from its system clock and the highest step rate it expects, allowing about ten clocks per step.

Top module: `qenc_counter`

## Requirements
- R1: The phase state is {enc_a_i, enc_b_i}, with A as the MSB. Moving one place forward in the cyclic order 00 -> 10 -> 11 -> 01 -> 00 adds one to the count on that sample. Moving one place backward subtracts one.
- R2: A sample whose state equals the previous state leaves the count unchanged. A sample where both bits changed at once (00<->11, 01<->10) also leaves the count unchanged.
- R3: The count is CNT_W bits (32 by default) and wraps modulo 2^CNT_W in both directions.
- R4: On every sample tick the post-update count is written to the queue if the queue held fewer than FIFO_DEPTH entries (4 by default) before that clock edge. Otherwise the value is dropped. level_o reports the occupancy and never exceeds FIFO_DEPTH.
- R5: rd_valid_o is high exactly when rd_req_i is high and the queue is not empty. rd_data_o then carries the oldest entry, and that entry is removed at the same clock edge.
- R6: A host that pops level_o entries and then one more entry, with the inputs held steady, receives the count that reflects every input change made before the read began.
- R7: With div_i equal to 0 or 1, a sample is taken on every clock. With div_i equal to N >= 2, exactly one sample is taken every N clocks. Between samples the count does not change.
- R8: After reset, the first sample taken once the synchroniser holds valid data loads the previous state from the inputs and does not count. A reset applied while the inputs are at a non-zero state therefore still yields a count of 0.
- R9: While rst_ni is low the count is 0, the queue is empty (level_o = 0, rd_valid_o = 0), and the divider counter is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 1 | Encoder phase A, asynchronous |
| enc_b_i | input | 1 | Encoder phase B, asynchronous |
| div_i | input | DIV_W | Sample divisor; 0 or 1 samples every clock |
| rd_req_i | input | 1 | Host pop request |
| rd_valid_o | output | 1 | Popped entry valid this cycle |
| rd_data_o | output | CNT_W | Oldest queued count |
| level_o | output | $clog2(FIFO_DEPTH+1) | Queue occupancy |

## Verification
A wrong entry in the step table, or a wrong wrap, appears at the ports as a count difference between two fresh reads. That difference shows up three clocks after the phase change when sampling runs every clock. A stale previous state or a missed priming sample after reset produces a spurious count, and the first fresh read after reset exposes it. Queue faults show up in how level_o evolves and in which values the drain sequence returns: an overwrite instead of a drop, or a push that lands in a full queue, returns a new value where an old one was expected. A divider fault changes the spacing between rises of level_o.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

  // index = {previous state, new state}, each {A,B}
  function automatic step_e decode_step(input logic [3:0] idx);
    step_e s;
    case (idx)
      4'b0010, 4'b1011, 4'b1101, 4'b0100: s = STEP_INC;
      4'b0001, 4'b0111, 4'b1110, 4'b1000: s = STEP_DEC;
      default:                            s = STEP_HOLD;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         vld_o
);
  logic [W-1:0] s1_q, s2_q;
  logic [1:0]   vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= '0;
      s2_q  <= '0;
      vld_q <= '0;
    end else begin
      s1_q  <= d_i;
      s2_q  <= s1_q;
      vld_q <= {vld_q[0], 1'b1};
    end
  end

  assign q_o   = s2_q;
  assign vld_o = vld_q[1];
endmodule

// File: rtl/qenc_div.sv
module qenc_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             bypass;

  assign bypass = (div_i <= DIV_W'(1));
  assign tick_o = bypass || (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= bypass ? '0 : div_i - DIV_W'(1);
    else             cnt_q <= cnt_q - DIV_W'(1);
  end

  AST_DIV_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i > DIV_W'(1)) |=> (!tick_o || div_i <= DIV_W'(1))); // R7
endmodule

// File: rtl/qenc_fifo.sv
module qenc_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] level_q;
  logic             push_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign push_ok = push_i && (level_q < LVL_W'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
    end else begin
      if (push_ok) wr_q <= ptr_inc(wr_q);
      if (pop_i)   rd_q <= ptr_inc(rd_q);
      level_q <= level_q + LVL_W'(push_ok) - LVL_W'(pop_i);
    end
  end

  assign data_o  = mem_q[rd_q];
  assign empty_o = (level_q == '0);
  assign level_o = level_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LVL_W'(DEPTH)); // R4
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q == LVL_W'(DEPTH) && push_i && !pop_i) |=> level_q == LVL_W'(DEPTH)); // R4
  AST_PUSH_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && level_q < LVL_W'(DEPTH)) |=> level_q == $past(level_q) + LVL_W'(1)); // R4
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> level_q != '0); // R5
endmodule

// File: rtl/qenc_core.sv
module qenc_core
  import qenc_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             vld_i,
  input  logic [1:0]       pins_i,
  output logic             push_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [1:0]       prev_q;
  logic             primed_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sample;
  step_e            step;

  assign sample = tick_i && vld_i;
  assign step   = decode_step({prev_q, pins_i});

  always_comb begin
    cnt_d = cnt_q;
    if (sample && primed_q) begin
      case (step)
        STEP_INC: cnt_d = cnt_q + CNT_W'(1);
        STEP_DEC: cnt_d = cnt_q - CNT_W'(1);
        default:  cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      cnt_q    <= '0;
    end else if (sample) begin
      prev_q   <= pins_i;
      primed_q <= 1'b1;
      cnt_q    <= cnt_d;
    end
  end

  assign push_o    = sample;
  assign cnt_nxt_o = cnt_d;

  AST_STEP_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)
              || cnt_q == $past(cnt_q) - CNT_W'(1))); // R1
  AST_DOUBLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample && primed_q && (prev_q ^ pins_i) == 2'b11) |=> $stable(cnt_q)); // R2
  AST_SAME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample && prev_q == pins_i) |=> $stable(cnt_q)); // R2
  AST_PRIME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample && !primed_q) |=> $stable(cnt_q)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned DIV_W      = 16,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enc_a_i,
  input  logic             enc_b_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rd_req_i,
  output logic             rd_valid_o,
  output logic [CNT_W-1:0] rd_data_o,
  output logic [LVL_W-1:0] level_o
);
  logic [1:0]       pins;
  logic             pins_vld, tick, push, empty;
  logic [CNT_W-1:0] cnt_nxt;

  qenc_sync #(.W(2)) u_sync (
    .clk_i, .rst_ni, .d_i({enc_a_i, enc_b_i}), .q_o(pins), .vld_o(pins_vld)
  );

  qenc_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .div_i, .tick_o(tick)
  );

  qenc_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .tick_i(tick), .vld_i(pins_vld), .pins_i(pins),
    .push_o(push), .cnt_nxt_o(cnt_nxt)
  );

  assign rd_valid_o = rd_req_i && !empty;

  qenc_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .data_i(cnt_nxt), .pop_i(rd_valid_o),
    .data_o(rd_data_o), .empty_o(empty), .level_o(level_o)
  );

  AST_RESET_EMPTY: assert property (@(posedge clk_i)
    !rst_ni |-> (level_o == '0 && !rd_valid_o)); // R9
endmodule

// File: tb/qenc_counter_bench.sv
module qenc_counter_bench;
  localparam int CW = 8;
  localparam int DEPTH = 4;
  localparam int DW = 8;
  localparam int LW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a = 1'b0, b = 1'b0;
  logic [DW-1:0] div = '0;
  logic          rd_req = 1'b0;
  logic          rd_valid;
  logic [CW-1:0] rd_data;
  logic [LW-1:0] level;

  int checks = 0;
  int fails  = 0;
  int model  = 0;

  always #5 clk = ~clk;

  qenc_counter #(.CNT_W(CW), .FIFO_DEPTH(DEPTH), .DIV_W(DW)) u_qenc_counter (
    .clk_i(clk), .rst_ni(rst_n), .enc_a_i(a), .enc_b_i(b), .div_i(div),
    .rd_req_i(rd_req), .rd_valid_o(rd_valid), .rd_data_o(rd_data), .level_o(level)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pos(input logic [1:0] s);
    return (s == 2'b00) ? 0 : (s == 2'b10) ? 1 : (s == 2'b11) ? 2 : 3;
  endfunction

  function automatic int exp_step(input logic [1:0] p, input logic [1:0] n);
    int d;
    d = (pos(n) - pos(p) + 4) % 4;
    return (d == 1) ? 1 : (d == 3) ? -1 : 0;
  endfunction

  task automatic set_pins(input logic [1:0] s);
    @(negedge clk);
    {a, b} = s;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_fresh(output logic [CW-1:0] v);
    int n;
    @(negedge clk);
    n = int'(level) + 1;
    v = '0;
    while (n > 0) begin
      rd_req = 1'b1;
      #1;
      if (rd_valid) begin
        v = rd_data;
        n--;
      end
      @(negedge clk);
    end
    rd_req = 1'b0;
  endtask

  task automatic drain_empty();
    @(negedge clk);
    forever begin
      rd_req = 1'b1;
      #1;
      if (!rd_valid) break;
      @(negedge clk);
    end
    rd_req = 1'b0;
  endtask

  task automatic walk(input int steps, input int dir, input int hold);
    logic [1:0] seq [4] = '{2'b00, 2'b10, 2'b11, 2'b01};
    int idx;
    idx = pos({a, b});
    for (int i = 0; i < steps; i++) begin
      idx = (idx + dir + 4) % 4;
      set_pins(seq[idx]);
      model += dir;
      wait_cyc(hold);
    end
  endtask

  initial begin
    logic [CW-1:0] c0, c1;
    int t[3];
    int k;
    logic [1:0] fl;
    {a, b} = 2'b01;
    #1;
    check(level == '0, "R9 level in reset", int'(level), 0);
    rd_req = 1'b1;
    #1;
    check(!rd_valid, "R9 valid in reset", int'(rd_valid), 0);
    rd_req = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(8);
    read_fresh(c0);
    check(c0 == 0, "R8 primed from nonzero pins", int'(c0), 0);

    // R1 R2: all 16 transitions
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 4; n++) begin
        set_pins(2'(p));
        wait_cyc(5);
        read_fresh(c0);
        set_pins(2'(n));
        wait_cyc(5);
        read_fresh(c1);
        k = exp_step(2'(p), 2'(n));
        check(c1 - c0 == CW'(k), (k == 0) ? "R2 hold" : "R1 step",
              int'(CW'(c1 - c0)), int'(CW'(k)));
      end
    end

    // R3: wrap forward and backward
    set_pins(2'b00);
    wait_cyc(5);
    read_fresh(c0);
    model = int'(c0);
    walk(300, 1, 3);
    read_fresh(c1);
    check(c1 == CW'(model), "R3 forward wrap", int'(c1), int'(CW'(model)));
    walk(600, -1, 3);
    read_fresh(c1);
    check(c1 == CW'(model), "R3 backward wrap", int'(c1), int'(CW'(model)));

    // R4 R6: full queue drops new values, drain+1 returns fresh
    wait_cyc(10);
    check(level == LW'(DEPTH), "R4 level saturates", int'(level), DEPTH);
    read_fresh(c0);
    wait_cyc(10);
    walk(1, 1, 6);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      rd_req = 1'b1;
      #1;
      check(rd_valid && rd_data == c0, "R4 full drops new", int'(rd_data), int'(c0));
    end
    @(negedge clk);
    rd_req = 1'b0;
    read_fresh(c1);
    check(c1 == CW'(model), "R6 fresh after drain", int'(c1), int'(CW'(model)));

    // R5: valid only with request and non-empty queue
    wait_cyc(2);
    #1;
    check(!rd_valid, "R5 no request no valid", int'(rd_valid), 0);

    // R7: divider spacing
    @(negedge clk);
    div = DW'(5);
    wait_cyc(12);
    drain_empty();
    #1;
    check(level == '0, "R5 drained empty", int'(level), 0);
    k = 0;
    for (int cyc = 0; cyc < 40 && k < 3; cyc++) begin
      @(negedge clk);
      #1;
      if (int'(level) == k + 1) begin
        t[k] = cyc;
        k++;
      end
    end
    check(k == 3 && t[1] - t[0] == 5, "R7 divide by 5 gap", t[1] - t[0], 5);
    check(k == 3 && t[2] - t[1] == 5, "R7 divide by 5 gap", t[2] - t[1], 5);
    drain_empty();
    div = DW'(0);
    @(negedge clk);
    #1;
    fl = 2'(level);
    @(negedge clk);
    #1;
    check(int'(level) == int'(fl) + 1, "R7 every clock at div 0", int'(level), int'(fl) + 1);

    // R7: counting stays correct under a divider
    @(negedge clk);
    div = DW'(3);
    read_fresh(c0);
    model = int'(c0);
    walk(20, 1, 5);
    walk(7, -1, 5);
    wait_cyc(6);
    read_fresh(c1);
    check(c1 == CW'(model), "R7 count with divider", int'(c1), int'(CW'(model)));

    // R9: reset mid-run
    set_pins(2'b11);
    wait_cyc(6);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(level == '0, "R9 queue cleared", int'(level), 0);
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(8);
    read_fresh(c1);
    check(c1 == 0, "R9 count cleared", int'(c1), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule